// File: doc/BRIEF.md
# Shared-Memory Video Slot Sequencer

This block lets a character display and a CPU share a single RAM without display corruption. It splits every character cell of eight pixel-clock ticks into fixed ownership slots.

- In tick 0 the address multiplexer is handed to a framebuffer fetch, and the byte read is held in a latch.
- In tick 1 a pattern fetch uses that held byte, added to a pattern-base offset, as its address.
- In the other six ticks the CPU owns the address bus, the data bus and the memory controls.

Because the video fetches sit in fixed slots, any RAM location can serve as video memory. The CPU sees a fixed, cycle-countable share of the bus.

External video counters supply the character index and an active-display flag. Two 16-bit base registers can be written from the CPU side: one for the framebuffer and one for the pattern table. The pattern byte is loaded into an output shift register in the last tick of the cell, so its pixels appear across the next cell, most significant bit first.

Top module: `vid_slot_seq`

## Requirements
- R1: While rst_ni is low, the tick phase is held at tick 0: owner_o = 2'b01, load_o = 0, pix_o = 0. Both base registers are cleared, so mem_addr_o equals the zero-extended char_idx_i.
- R2: owner_o encodes the bus owner as 2'b00 for CPU, 2'b01 for the framebuffer fetch and 2'b10 for the pattern fetch. It follows the repeating tick sequence 0..7, giving 01 in tick 0, 10 in tick 1 and 00 in ticks 2 to 7. It changes only at rising edges of clk_i.
- R3: Whenever owner_o is 2'b00, mem_addr_o equals cpu_addr_i.
- R4: In tick 0, mem_addr_o is the framebuffer base plus the zero-extended char_idx_i, modulo 2^16.
- R5: In tick 1, mem_addr_o is the pattern base plus the mem_rdata_i byte captured at the end of tick 0 of the same cell, modulo 2^16.
- R6: A cycle with cfg_we_i high writes cfg_wdata_i into the framebuffer base (cfg_sel_i = 0) or the pattern base (cfg_sel_i = 1). The new value is used from the next cycle. A fetch in the same cycle as the write still uses the old value.
- R7: load_o is high in tick 7 only.
- R8: After a load, pix_o presents the loaded pattern byte across ticks 0 to 7 of the next cell, bit 7 in tick 0 down to bit 0 in tick 7.
- R9: If active_i is low in tick 1, the whole pixel row produced from that cell is zero. The slot sequence is unchanged.
- R10: mem_rdata_i is ignored in every tick other than 0 and 1. It has no effect on later addresses or pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Active-display flag from the video counters |
| char_idx_i | input | 12 | Character index from the video counters |
| cpu_addr_i | input | 16 | CPU address |
| cfg_we_i | input | 1 | Base-register write strobe |
| cfg_sel_i | input | 1 | 0 selects the framebuffer base, 1 selects the pattern base |
| cfg_wdata_i | input | 16 | Base-register write data |
| mem_rdata_i | input | 8 | RAM read data |
| mem_addr_o | output | 16 | Multiplexed RAM address |
| owner_o | output | 2 | Current bus owner |
| load_o | output | 1 | Shift-register load strobe |
| pix_o | output | 1 | Serial pixel output |

## Verification
A base-register write can land in the same cycle as the fetch that reads that base. The bench provokes this both with random write strobes and with directed writes placed exactly in tick 0 and tick 1. A behavioural reference applies the fetch before the write, so the address in that cycle is judged against the old base and the next cell's address against the new one. Blanking is also toggled on and off in the pattern slot, where it falls together with the pattern fetch. The bench compares the address, owner, strobe and pixel on every clock.

// File: rtl/vss_pkg.sv
`timescale 1ns/1ps
package vss_pkg;
  typedef enum logic [1:0] {
    OWN_CPU = 2'b00,
    OWN_FB  = 2'b01,
    OWN_PAT = 2'b10
  } owner_e;
endpackage

// File: rtl/vss_slot_ctrl.sv
`timescale 1ns/1ps
module vss_slot_ctrl #(
  parameter int CELL_W = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic [1:0] owner_o,
  output logic       fb_slot_o,
  output logic       pat_slot_o,
  output logic       load_o
);
  import vss_pkg::*;

  localparam logic [CELL_W-1:0] TICK_FB   = '0;
  localparam logic [CELL_W-1:0] TICK_ONE  = {{(CELL_W-1){1'b0}}, 1'b1};
  localparam logic [CELL_W-1:0] TICK_PAT  = TICK_ONE;
  localparam logic [CELL_W-1:0] TICK_LAST = '1;

  logic [CELL_W-1:0] tick_q;
  owner_e            owner;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= '0;
    else         tick_q <= tick_q + TICK_ONE;
  end

  always_comb begin
    fb_slot_o  = (tick_q == TICK_FB);
    pat_slot_o = (tick_q == TICK_PAT);
    load_o     = (tick_q == TICK_LAST);
    if (fb_slot_o)       owner = OWN_FB;
    else if (pat_slot_o) owner = OWN_PAT;
    else                 owner = OWN_CPU;
  end

  assign owner_o = owner;

  assert_owner_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_o));
  assert_fb_then_pat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o == 2'b01 |=> owner_o == 2'b10);
  assert_pat_then_cpu_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o == 2'b10 |=> owner_o == 2'b00);
  assert_load_before_fb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> owner_o == 2'b01);
  assert_load_not_in_slot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> owner_o == 2'b00);
endmodule

// File: rtl/vss_addr_mux.sv
`timescale 1ns/1ps
module vss_addr_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fb_slot_i,
  input  logic              pat_slot_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic [IDX_W-1:0]  char_idx_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o
);
  localparam int IDX_PAD  = ADDR_W - IDX_W;
  localparam int CODE_PAD = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] fb_base_q, pat_base_q;
  logic [DATA_W-1:0] code_q;
  logic [ADDR_W-1:0] fb_addr, pat_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_base_q  <= '0;
      pat_base_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i) pat_base_q <= cfg_wdata_i;
      else           fb_base_q  <= cfg_wdata_i;
    end
  end

  // character code latched from the framebuffer slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        code_q <= '0;
    else if (fb_slot_i) code_q <= mem_rdata_i;
  end

  always_comb begin
    fb_addr  = fb_base_q + {{IDX_PAD{1'b0}}, char_idx_i};
    pat_addr = pat_base_q + {{CODE_PAD{1'b0}}, code_q};
    if (fb_slot_i)       mem_addr_o = fb_addr;
    else if (pat_slot_i) mem_addr_o = pat_addr;
    else                 mem_addr_o = cpu_addr_i;
  end

  assert_fb_base_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && !cfg_sel_i |=> fb_base_q == $past(cfg_wdata_i));
  assert_pat_base_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && cfg_sel_i |=> pat_base_q == $past(cfg_wdata_i));
  assert_code_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fb_slot_i |=> $stable(code_q));
  assert_slots_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fb_slot_i && pat_slot_i));
endmodule

// File: rtl/vss_shifter.sv
`timescale 1ns/1ps
module vss_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pat_slot_i,
  input  logic              load_i,
  input  logic              active_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pix_o
);
  logic [DATA_W-1:0] pat_q, sh_q;

  // blanked cells yield a zero row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pat_q <= '0;
    else if (pat_slot_i) pat_q <= active_i ? mem_rdata_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= pat_q;
    else              sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign pix_o = sh_q[DATA_W-1];

  assert_load_takes_pattern_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sh_q == $past(pat_q));
  assert_blank_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_slot_i && !active_i |=> pat_q == '0);
  assert_pattern_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pat_slot_i |=> $stable(pat_q));
endmodule

// File: rtl/vid_slot_seq.sv
`timescale 1ns/1ps
module vid_slot_seq #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [IDX_W-1:0]  char_idx_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        owner_o,
  output logic              load_o,
  output logic              pix_o
);
  // one tick per pixel, so the cell spans DATA_W ticks
  localparam int CELL_W = $clog2(DATA_W);

  logic fb_slot, pat_slot;

  vss_slot_ctrl #(.CELL_W(CELL_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .owner_o    (owner_o),
    .fb_slot_o  (fb_slot),
    .pat_slot_o (pat_slot),
    .load_o     (load_o)
  );

  vss_addr_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fb_slot_i   (fb_slot),
    .pat_slot_i  (pat_slot),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .char_idx_i  (char_idx_i),
    .cpu_addr_i  (cpu_addr_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o)
  );

  vss_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pat_slot_i  (pat_slot),
    .load_i      (load_o),
    .active_i    (active_i),
    .mem_rdata_i (mem_rdata_i),
    .pix_o       (pix_o)
  );

  assert_cpu_passthrough_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_o == 2'b00 |-> mem_addr_o == cpu_addr_i);
endmodule

// File: tb/sim_vid_slot_seq.sv
`timescale 1ns/1ps
module sim_vid_slot_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        active = 1'b1;
  logic [11:0] idx = '0;
  logic [15:0] cpu_addr = '0;
  logic        we = 1'b0;
  logic        sel = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] mem_addr;
  logic [1:0]  owner;
  logic        load;
  logic        pix;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] ram(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign rdata = ram(mem_addr);

  vid_slot_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .active_i(active), .char_idx_i(idx),
    .cpu_addr_i(cpu_addr), .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata),
    .mem_rdata_i(rdata), .mem_addr_o(mem_addr), .owner_o(owner),
    .load_o(load), .pix_o(pix)
  );

  // behavioural reference
  int         m_tick;
  logic [15:0] m_fb_base, m_pat_base;
  logic [7:0]  m_code, m_pat;
  bit          m_q[$];

  function automatic logic [15:0] exp_addr();
    if (m_tick == 0) return m_fb_base + {4'h0, idx};
    if (m_tick == 1) return m_pat_base + {8'h00, m_code};
    return cpu_addr;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tick = 0; m_fb_base = '0; m_pat_base = '0; m_code = '0; m_pat = '0;
      m_q.delete();
    end else begin
      // fetch uses pre-write bases
      if (m_tick == 0) m_code = ram(m_fb_base + {4'h0, idx});
      if (m_tick == 1) m_pat = active ? ram(m_pat_base + {8'h00, m_code}) : 8'h00;
      if (m_tick == 7) begin
        m_q.delete();
        for (int i = 7; i >= 0; i--) m_q.push_back(m_pat[i]);
      end else if (m_q.size() > 0) begin
        void'(m_q.pop_front());
      end
      if (we) begin
        if (sel) m_pat_base = wdata;
        else     m_fb_base  = wdata;
      end
      m_tick = (m_tick + 1) % 8;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      logic [1:0] e_own;
      logic       e_pix;
      e_own = (m_tick == 0) ? 2'b01 : (m_tick == 1) ? 2'b10 : 2'b00;
      e_pix = (m_q.size() > 0) ? m_q[0] : 1'b0;
      if (!rst_n) begin
        chk("R1 owner", {14'h0, owner}, {14'h0, e_own});
        chk("R1 addr", mem_addr, exp_addr());
        chk("R1 load", {15'h0, load}, 16'h0);
        chk("R1 pix", {15'h0, pix}, 16'h0);
      end else begin
        chk("R2 owner", {14'h0, owner}, {14'h0, e_own});
        if (m_tick == 0)      chk("R4/R6 fb addr", mem_addr, exp_addr());
        else if (m_tick == 1) chk("R5/R6 pat addr", mem_addr, exp_addr());
        else                  chk("R3 cpu addr", mem_addr, exp_addr());
        chk("R7 load", {15'h0, load}, {15'h0, m_tick == 7});
        chk("R8/R9/R10 pix", {15'h0, pix}, {15'h0, e_pix});
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    idx = 12'($urandom);
    cpu_addr = 16'($urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 R3 R4 R5 R8: steady display
    repeat (400) step();
    // R6: random base writes, some in fetch slots
    repeat (400) begin
      step();
      we = ($urandom % 4) == 0;
      sel = 1'($urandom);
      wdata = 16'($urandom);
    end
    // R6: directed writes exactly in tick 0 and tick 1
    for (int k = 0; k < 24; k++) begin
      step();
      we = 1'b0;
      while (m_tick != (k % 2)) step();
      we = 1'b1; sel = 1'((k / 2) % 2); wdata = 16'($urandom);
    end
    step(); we = 1'b0;
    // R9 R10: blanking toggled per cycle
    repeat (600) begin
      step();
      active = 1'($urandom);
    end
    active = 1'b1;
    // R1: mid-run reset
    step(); rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (200) step();
    @(negedge clk); #1;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule